// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page mappings and turns a virtual page number plus a byte offset into a physical address. Every lookup is compared against all stored entries in the same cycle, and the answer appears one clock after the request. Each stored mapping carries its own permission flags, a dirty flag and a cache-disable flag. Those flags are checked on every hit, so a hit can also end in a protection fault.

When no entry matches, the block does not report a fault. It raises a one-cycle request to an external page table walker and holds on to the page number it needs. When the walker returns a good mapping, the block installs it. When the walker reports failure, the block turns that into a page fault pulse. A store to a mapping whose dirty flag is clear also goes to the walker, so that memory can record the modification before the store goes ahead. The returned entry then overwrites the stale copy in place.

A flush input invalidates every entry at once. Two counters, one for hits and one for misses, let a test measure the hit ratio.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rsp_valid_o`, `walk_req_o` and `page_fault_o` are 0, and both counters read 0.
- R2: A lookup presented with `req_valid_i` is answered one cycle later with `rsp_valid_o`=1. It is a hit when a valid entry holds `req_vpn_i`, the permission allows the access and the dirty rule of R5 does not apply. On a hit `rsp_paddr_o` = {stored physical page, `req_off_i`} and `rsp_nocache_o` is the stored cache-disable flag.
- R3: The permission field is bit 2 read, bit 1 write and bit 0 execute. Access kinds are 0 load, 1 store, 2 fetch and 3 reserved (never allowed). A matching entry that forbids the access gives `rsp_prot_fault_o`=1 with `rsp_hit_o`=0, no walk request, and no change to either counter.
- R4: A lookup that matches no valid entry gives `rsp_hit_o`=0, `rsp_prot_fault_o`=0, `page_fault_o`=0 and a one-cycle `walk_req_o` in the response cycle, with `walk_vpn_o` equal to the looked-up page.
- R5: A store to a writable matching entry whose dirty flag is 0 is handled as a miss, with `walk_dirty_upd_o`=1. The mapping the walker returns for that page overwrites the existing entry, and all other entries are kept.
- R6: A `walk_done_i` with `walk_ok_i`=1 while a walk is outstanding installs the returned mapping. If no entry holds the page, the lowest-numbered invalid entry is used; when none is invalid, a round-robin pointer chooses the entry. The pointer starts at 0 after reset and advances by one on every installation, including overwrites.
- R7: A `walk_done_i` with `walk_ok_i`=0 while a walk is outstanding gives a one-cycle `page_fault_o` in the next cycle and installs nothing.
- R8: A `walk_done_i` with no walk outstanding is ignored: it installs nothing and raises no page fault.
- R9: `flush_i` invalidates every entry in one cycle and wins over an installation in the same cycle.
- R10: `hit_count_o` rises by one per hit response and `miss_count_o` by one per lookup that raises `walk_req_o`. Both counters update in the response cycle.
- R11: No two valid entries ever hold the same virtual page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| req_off_i | input | OFF_W | Byte offset within the page |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_hit_o | output | 1 | Translation returned |
| rsp_prot_fault_o | output | 1 | Matching entry forbids the access |
| rsp_paddr_o | output | PPN_W+OFF_W | Physical address on a hit |
| rsp_nocache_o | output | 1 | Cache-disable flag of the hit entry |
| walk_req_o | output | 1 | Request to the page table walker |
| walk_vpn_o | output | VPN_W | Page the walker should resolve |
| walk_dirty_upd_o | output | 1 | Walk was raised to set the dirty flag |
| walk_done_i | input | 1 | Walker finished |
| walk_ok_i | input | 1 | Walker found a valid mapping |
| walk_ppn_i | input | PPN_W | Returned physical page |
| walk_perm_i | input | 3 | Returned permission: read, write, execute |
| walk_dirty_i | input | 1 | Returned dirty flag |
| walk_nocache_i | input | 1 | Returned cache-disable flag |
| page_fault_o | output | 1 | Failed walk reported as fault |
| hit_count_o | output | CNT_W | Number of hit responses |
| miss_count_o | output | CNT_W | Number of lookups that raised a walk |

## Verification
The bench first fills all eight entries with mixed permissions and flags. It then goes after the cases a careless design mixes up. A store to a read-only page must fault and must not request a walk. A store to a clean writable page must miss with the dirty-upgrade flag set. A design that skipped this rule would return an address and let the write go ahead with the dirty state still clean in memory. After the dirty upgrade, every other entry must still hit. A design that placed the refill in a victim slot would leave a duplicate entry and lose another mapping. The next eviction must displace entry 1 and keep entry 0, which shows the round-robin pointer also advanced on the overwrite. A failed walk must fault without installing. A stray walk completion and a completion in the same cycle as a flush must both install nothing, which the bench sees as later misses.

// File: rtl/xlat_pkg.sv
// Shared types for the translation cache.
// Assumes: permission field is packed read, write, execute from MSB down.
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    // Decide whether an access kind is allowed by a permission set.
    function automatic logic perm_allows(perm_t p, logic [1:0] kind);
        case (acc_kind_e'(kind))
            ACC_LOAD:  return p.rd;
            ACC_STORE: return p.wr;
            ACC_FETCH: return p.ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xlat_match.sv
// Parallel tag compare across every entry.
// Assumes at most one valid entry holds a given key, so the index
// encoding may simply OR together the positions that match.
module xlat_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic [ENTRIES-1:0]            hit_vec_o,
    output logic                          any_o,
    output logic [IDX_W-1:0]              idx_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    assign any_o = |hit_vec_o;

    // Encode the matching position into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot for a new mapping: lowest invalid slot first,
// otherwise a round-robin pointer that steps on every installation.
// Assumes ENTRIES >= 2.
module xlat_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               adv_i,
    output logic [IDX_W-1:0]   victim_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Step the round-robin pointer on each installation, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)      rr_q <= '0;
        else if (adv_i)  rr_q <= (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
    end

    // Find the lowest-numbered invalid slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_o = free_any ? free_idx : rr_q;

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache with permission, dirty and
// cache-disable flags per entry.
// Assumes the walker serves one outstanding request; a newer miss
// replaces the page recorded for the walk.
module xlat_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic                    req_valid_i,
    input  logic [VPN_W-1:0]        req_vpn_i,
    input  logic [OFF_W-1:0]        req_off_i,
    input  logic [1:0]              req_kind_i,
    output logic                    rsp_valid_o,
    output logic                    rsp_hit_o,
    output logic                    rsp_prot_fault_o,
    output logic [PPN_W+OFF_W-1:0]  rsp_paddr_o,
    output logic                    rsp_nocache_o,
    output logic                    walk_req_o,
    output logic [VPN_W-1:0]        walk_vpn_o,
    output logic                    walk_dirty_upd_o,
    input  logic                    walk_done_i,
    input  logic                    walk_ok_i,
    input  logic [PPN_W-1:0]        walk_ppn_i,
    input  logic [2:0]              walk_perm_i,
    input  logic                    walk_dirty_i,
    input  logic                    walk_nocache_i,
    output logic                    page_fault_o,
    output logic [CNT_W-1:0]        hit_count_o,
    output logic [CNT_W-1:0]        miss_count_o
);
    import xlat_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
    perm_t [ENTRIES-1:0]           ent_perm;
    logic [ENTRIES-1:0]            ent_dirty;
    logic [ENTRIES-1:0]            ent_nc;

    // Lookup path
    logic [ENTRIES-1:0] look_hit_vec;
    logic               look_any;
    logic [IDX_W-1:0]   look_idx;
    logic               look_perm_ok;
    logic               look_need_dirty;
    logic               lk_hit, lk_pf, lk_miss;

    // Refill path
    logic [ENTRIES-1:0] refill_hit_vec;
    logic               refill_any;
    logic [IDX_W-1:0]   refill_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_en;
    logic               pend_q;
    logic [VPN_W-1:0]   walk_vpn_q;

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_look (
        .valid_i   (ent_valid),
        .tags_i    (ent_vpn),
        .key_i     (req_vpn_i),
        .hit_vec_o (look_hit_vec),
        .any_o     (look_any),
        .idx_o     (look_idx)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_refill (
        .valid_i   (ent_valid),
        .tags_i    (ent_vpn),
        .key_i     (walk_vpn_q),
        .hit_vec_o (refill_hit_vec),
        .any_o     (refill_any),
        .idx_o     (refill_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (ent_valid),
        .adv_i    (fill_en),
        .victim_o (victim_idx)
    );

    // Classify the current lookup as hit, protection fault or miss.
    always_comb begin
        look_perm_ok    = perm_allows(ent_perm[look_idx], req_kind_i);
        look_need_dirty = (acc_kind_e'(req_kind_i) == ACC_STORE) && !ent_dirty[look_idx];
        lk_hit  = req_valid_i && look_any && look_perm_ok && !look_need_dirty;
        lk_pf   = req_valid_i && look_any && !look_perm_ok;
        lk_miss = req_valid_i && (!look_any || (look_perm_ok && look_need_dirty));
    end

    // An existing copy of the page is overwritten; otherwise use the victim.
    assign fill_en  = walk_done_i && walk_ok_i && pend_q && !flush_i;
    assign fill_idx = refill_any ? refill_idx : victim_idx;

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o      <= 1'b0;
            rsp_hit_o        <= 1'b0;
            rsp_prot_fault_o <= 1'b0;
            rsp_paddr_o      <= '0;
            rsp_nocache_o    <= 1'b0;
        end else begin
            rsp_valid_o      <= req_valid_i;
            rsp_hit_o        <= lk_hit;
            rsp_prot_fault_o <= lk_pf;
            rsp_paddr_o      <= lk_hit ? {ent_ppn[look_idx], req_off_i} : '0;
            rsp_nocache_o    <= lk_hit && ent_nc[look_idx];
        end
    end

    // Track the outstanding walk and raise its request and fault strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_req_o       <= 1'b0;
            walk_vpn_q       <= '0;
            walk_dirty_upd_o <= 1'b0;
            pend_q           <= 1'b0;
            page_fault_o     <= 1'b0;
        end else begin
            walk_req_o   <= lk_miss;
            page_fault_o <= walk_done_i && !walk_ok_i && pend_q;
            if (lk_miss) begin
                walk_vpn_q       <= req_vpn_i;
                walk_dirty_upd_o <= look_any;
                pend_q           <= 1'b1;
            end else if (walk_done_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign walk_vpn_o = walk_vpn_q;

    // Update entry storage: flush wins over an installation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_vpn   <= '0;
            ent_ppn   <= '0;
            ent_perm  <= '0;
            ent_dirty <= '0;
            ent_nc    <= '0;
        end else if (flush_i) begin
            ent_valid <= '0;
        end else if (fill_en) begin
            ent_valid[fill_idx] <= 1'b1;
            ent_vpn[fill_idx]   <= walk_vpn_q;
            ent_ppn[fill_idx]   <= walk_ppn_i;
            ent_perm[fill_idx]  <= perm_t'(walk_perm_i);
            ent_dirty[fill_idx] <= walk_dirty_i;
            ent_nc[fill_idx]    <= walk_nocache_i;
        end
    end

    // Count hits and walk-raising misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count_o  <= '0;
            miss_count_o <= '0;
        end else begin
            if (lk_hit)  hit_count_o  <= hit_count_o + CNT_W'(1);
            if (lk_miss) miss_count_o <= miss_count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
// Temporal checks on the translation cache, bound to every instance.
// Assumes it observes internal entry state through the bind connections.
module xlat_cache_chk #(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               rsp_hit_o,
    input logic               rsp_prot_fault_o,
    input logic               rsp_valid_o,
    input logic               walk_req_o,
    input logic               walk_done_i,
    input logic               walk_ok_i,
    input logic               page_fault_o,
    input logic [CNT_W-1:0]   hit_count_o,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] look_hit_vec,
    input logic               pend_q
);

    // R3
    hit_pf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit_o && rsp_prot_fault_o));

    // R4
    walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_o |-> (rsp_valid_o && !rsp_hit_o && !rsp_prot_fault_o));

    // R7
    fault_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done_i && !walk_ok_i && pend_q) |=> page_fault_o);

    // R8
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done_i && !pend_q && !flush_i) |=> ($stable(ent_valid) && !page_fault_o));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ent_valid == '0));

    // R10
    hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> (hit_count_o == $past(hit_count_o) + CNT_W'(1)));

    // R11
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit_vec));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .rsp_hit_o        (rsp_hit_o),
    .rsp_prot_fault_o (rsp_prot_fault_o),
    .rsp_valid_o      (rsp_valid_o),
    .walk_req_o       (walk_req_o),
    .walk_done_i      (walk_done_i),
    .walk_ok_i        (walk_ok_i),
    .page_fault_o     (page_fault_o),
    .hit_count_o      (hit_count_o),
    .ent_valid        (ent_valid),
    .look_hit_vec     (look_hit_vec),
    .pend_q           (pend_q)
);

// File: tb/xlat_cache_tb.sv
// Self-checking bench: fills, a vector table of mixed accesses, then
// directed cases for dirty upgrade, eviction, faults and flush.
module xlat_cache_tb;

    localparam int VPN_W = 20;
    localparam int PPN_W = 16;
    localparam int OFF_W = 12;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic [VPN_W-1:0] req_vpn_i = '0;
    logic [OFF_W-1:0] req_off_i = '0;
    logic [1:0] req_kind_i = '0;
    logic rsp_valid_o, rsp_hit_o, rsp_prot_fault_o, rsp_nocache_o;
    logic [PPN_W+OFF_W-1:0] rsp_paddr_o;
    logic walk_req_o, walk_dirty_upd_o, page_fault_o;
    logic [VPN_W-1:0] walk_vpn_o;
    logic walk_done_i = 1'b0, walk_ok_i = 1'b0;
    logic [PPN_W-1:0] walk_ppn_i = '0;
    logic [2:0] walk_perm_i = '0;
    logic walk_dirty_i = 1'b0, walk_nocache_i = 1'b0;
    logic [CNT_W-1:0] hit_count_o, miss_count_o;

    int checks = 0;
    int failures = 0;
    int exp_hits = 0;
    int exp_miss = 0;

    always #10 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_off_i(req_off_i),
        .req_kind_i(req_kind_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
        .rsp_prot_fault_o(rsp_prot_fault_o), .rsp_paddr_o(rsp_paddr_o),
        .rsp_nocache_o(rsp_nocache_o), .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o),
        .walk_dirty_upd_o(walk_dirty_upd_o), .walk_done_i(walk_done_i),
        .walk_ok_i(walk_ok_i), .walk_ppn_i(walk_ppn_i), .walk_perm_i(walk_perm_i),
        .walk_dirty_i(walk_dirty_i), .walk_nocache_i(walk_nocache_i),
        .page_fault_o(page_fault_o), .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
    );

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [1:0]       kind;
        logic             hit;
        logic             pf;
        logic             walk;
        logic             nc;
        logic             dup;
        logic [PPN_W-1:0] ppn;
    } vec_t;

    // Entry i (page 0x100+i): read always, write on even i, execute on i==5,
    // dirty when i%4==0, cache-disable on i==6, physical page 0x40+i.
    localparam vec_t VEC [8] = '{
        '{20'h00100, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0040},
        '{20'h00101, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{20'h00102, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000},
        '{20'h00104, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0044},
        '{20'h00105, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0045},
        '{20'h00103, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{20'h00106, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0046},
        '{20'h001FF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [1:0] kind,
                          input logic [OFF_W-1:0] off, input bit ehit, input bit epf,
                          input bit ewalk, input logic [PPN_W-1:0] eppn,
                          input bit enc, input bit edup, input string req);
        @(negedge clk);
        req_valid_i = 1'b1; req_vpn_i = vpn; req_kind_i = kind; req_off_i = off;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (ehit) exp_hits++;
        if (ewalk) exp_miss++;
        check(rsp_valid_o == 1'b1, req, "rsp_valid", 64'(rsp_valid_o), 64'(1));
        check(rsp_hit_o == ehit, req, "hit", 64'(rsp_hit_o), 64'(ehit));
        check(rsp_prot_fault_o == epf, req, "prot_fault", 64'(rsp_prot_fault_o), 64'(epf));
        check(walk_req_o == ewalk, req, "walk_req", 64'(walk_req_o), 64'(ewalk));
        if (ehit) begin
            check(rsp_paddr_o == {eppn, off}, req, "paddr", 64'(rsp_paddr_o), 64'({eppn, off}));
            check(rsp_nocache_o == enc, req, "nocache", 64'(rsp_nocache_o), 64'(enc));
        end
        if (ewalk) begin
            check(walk_vpn_o == vpn, req, "walk_vpn", 64'(walk_vpn_o), 64'(vpn));
            check(walk_dirty_upd_o == edup, req, "dirty_upd", 64'(walk_dirty_upd_o), 64'(edup));
            check(page_fault_o == 1'b0, "R4", "no page fault on miss", 64'(page_fault_o), 64'(0));
        end
    endtask

    task automatic walk(input bit ok, input logic [PPN_W-1:0] ppn, input logic [2:0] perm,
                        input bit dirty, input bit nc, input bit epf, input string req);
        @(negedge clk);
        walk_done_i = 1'b1; walk_ok_i = ok; walk_ppn_i = ppn;
        walk_perm_i = perm; walk_dirty_i = dirty; walk_nocache_i = nc;
        @(negedge clk);
        walk_done_i = 1'b0;
        check(page_fault_o == epf, req, "page_fault", 64'(page_fault_o), 64'(epf));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid_o == 0, "R1", "rsp_valid", 64'(rsp_valid_o), 0);
        check(walk_req_o == 0, "R1", "walk_req", 64'(walk_req_o), 0);
        check(page_fault_o == 0, "R1", "page_fault", 64'(page_fault_o), 0);
        check(hit_count_o == 0, "R1", "hit_count", 64'(hit_count_o), 0);
        check(miss_count_o == 0, "R1", "miss_count", 64'(miss_count_o), 0);

        // R6 fill all eight entries into invalid slots, R2 read each back
        for (int i = 0; i < 8; i++) begin
            lookup(20'h100 + 20'(i), 2'd0, 12'h010, 0, 0, 1, '0, 0, 0, "R4");
            walk(1, 16'h40 + 16'(i), {1'b1, (i % 2 == 0), (i == 5)},
                 (i % 4 == 0), (i == 6), 0, "R6");
            lookup(20'h100 + 20'(i), 2'd0, 12'h020 + 12'(i), 1, 0, 0,
                   16'h40 + 16'(i), (i == 6), 0, "R2");
        end

        // R2 R3 R5 vector table
        for (int v = 0; v < 8; v++) begin
            lookup(VEC[v].vpn, VEC[v].kind, 12'(v * 17 + 3), VEC[v].hit, VEC[v].pf,
                   VEC[v].walk, VEC[v].ppn, VEC[v].nc, VEC[v].dup,
                   VEC[v].pf ? "R3" : (VEC[v].dup ? "R5" : "R2"));
        end

        // R5 dirty upgrade overwrites in place; R11 others kept
        lookup(20'h102, 2'd1, 12'h0AB, 0, 0, 1, '0, 0, 1, "R5");
        walk(1, 16'h0042, 3'b110, 1, 0, 0, "R5");
        lookup(20'h102, 2'd1, 12'h0CD, 1, 0, 0, 16'h0042, 0, 0, "R5");
        for (int i = 0; i < 8; i++) begin
            lookup(20'h100 + 20'(i), 2'd0, 12'h300, 1, 0, 0, 16'h40 + 16'(i),
                   (i == 6), 0, "R11");
        end

        // R6 eviction: pointer at 1 after nine installations
        lookup(20'h200, 2'd0, 12'h001, 0, 0, 1, '0, 0, 0, "R6");
        walk(1, 16'h0080, 3'b111, 1, 0, 0, "R6");
        lookup(20'h200, 2'd0, 12'h002, 1, 0, 0, 16'h0080, 0, 0, "R6");
        lookup(20'h100, 2'd0, 12'h003, 1, 0, 0, 16'h0040, 0, 0, "R6");
        lookup(20'h101, 2'd0, 12'h004, 0, 0, 1, '0, 0, 0, "R6");

        // R7 failed walk faults and installs nothing
        walk(0, 16'h0099, 3'b111, 1, 0, 1, "R7");
        lookup(20'h101, 2'd0, 12'h005, 0, 0, 1, '0, 0, 0, "R7");
        walk(0, 16'h0099, 3'b111, 1, 0, 1, "R7");

        // R8 stray completion ignored
        walk(1, 16'h0099, 3'b111, 1, 0, 0, "R8");
        lookup(20'h101, 2'd0, 12'h006, 0, 0, 1, '0, 0, 0, "R8");

        // R9 flush wins over same-cycle installation
        @(negedge clk);
        flush_i = 1'b1; walk_done_i = 1'b1; walk_ok_i = 1'b1;
        walk_ppn_i = 16'h0055; walk_perm_i = 3'b111;
        @(negedge clk);
        flush_i = 1'b0; walk_done_i = 1'b0;
        lookup(20'h101, 2'd0, 12'h007, 0, 0, 1, '0, 0, 0, "R9");
        lookup(20'h100, 2'd0, 12'h008, 0, 0, 1, '0, 0, 0, "R9");
        lookup(20'h200, 2'd0, 12'h009, 0, 0, 1, '0, 0, 0, "R9");
        walk(1, 16'h0081, 3'b100, 0, 1, 0, "R6");
        lookup(20'h200, 2'd0, 12'h00A, 1, 0, 0, 16'h0081, 1, 0, "R6");

        // R10 counters
        check(hit_count_o == CNT_W'(exp_hits), "R10", "hit_count",
              64'(hit_count_o), 64'(exp_hits));
        check(miss_count_o == CNT_W'(exp_miss), "R10", "miss_count",
              64'(miss_count_o), 64'(exp_miss));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule